// File: doc/BRIEF.md
# Radar Range-Vector Threshold and Packing Stage

This block sits at the output end of a pulse-compression pipeline. It receives one range vector at a time as a stream of samples. Each sample has a 16-bit magnitude and a 16-bit phase. The first sample of a vector is flagged by `in_sov` and the last by `in_eov`. The block can discard weak returns against a programmable magnitude level and tag each surviving sample with its cell position. It also reduces each sample to one of three payload formats. The resulting entries are packed densely into 64-bit words for a downstream consumer.

Thresholding and format reduction are independent. The threshold can be switched off, so every sample passes without a cell index. Any payload format can be used with either setting. Configuration is captured with the first sample of each vector, so a vector is always processed under one consistent setting. Both sides use a valid/ready handshake. The input stalls only while a finished output word is waiting to be taken.

Top module: `rdr_thresh_pack`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With thresholding enabled, a sample is kept only when its magnitude is strictly greater than the threshold (unsigned compare). A sample equal to or below the threshold produces no entry.
- R3: The cell index is 0 for the start-of-vector sample and rises by one for every accepted sample, kept or discarded. With thresholding enabled, an entry carries the 16-bit index in its low bits and the payload directly above it.
- R4: With thresholding disabled, every sample produces an entry that holds the payload alone, with no index.
- R5: `cfg_mode` selects the payload. 0 gives the 16-bit magnitude. 1 gives 32 bits, with the magnitude in the low half and the phase in the high half. 2 gives the 8-bit log magnitude. 3 behaves as 0.
- R6: The log magnitude is 16 times the bit position of the leading one, plus the four bits just below that leading one. A magnitude of 0 gives 0.
- R7: Entries fill a word from bit 0 upward, back to back. A word is emitted once the next entry of the same width would no longer fit. Bits not covered by an entry are zero.
- R8: An end-of-vector sample always causes a word with `out_last` high. That word holds any pending entries, or is all zero if none are pending. Every other word has `out_last` low.
- R9: Threshold, mode and enable are taken from the configuration pins only on the start-of-vector sample. Their values on any other sample have no effect.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sov | input | 1 | Sample is the first of its vector |
| in_eov | input | 1 | Sample is the last of its vector |
| in_mag | input | 16 | Sample magnitude |
| in_phase | input | 16 | Sample phase |
| cfg_thresh | input | 16 | Threshold level |
| cfg_mode | input | 2 | Payload format select |
| cfg_thr_en | input | 1 | Threshold enable |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 64 | Packed output word |
| out_last | output | 1 | Word closes a vector |

## Verification
A word becomes visible on `out_data` one clock after the sample that completes or ends it is accepted. The word leaves on the first edge at which `out_ready` is high. `in_ready` responds in the same cycle to `out_valid` and `out_ready`. The bench sets all inputs just after a falling edge and reads the outputs a short delay later, in the same half cycle. It then treats a sample as consumed, or a word as delivered, exactly when the handshake holds there. Output words are checked in order against a reference queue built per vector from the requirements. The timing of the output therefore follows the handshake rather than a fixed latency.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  typedef enum logic [1:0] {
    FMT_MAG   = 2'd0,
    FMT_MAGPH = 2'd1,
    FMT_LOG   = 2'd2,
    FMT_RSV   = 2'd3
  } fmt_e;
endpackage

// File: rtl/rtp_log8.sv
// Leading-one based log approximation: position in the high bits,
// four following mantissa bits in the low bits.
module rtp_log8 #(
  parameter int MAG_W = 16,
  localparam int POS_W = $clog2(MAG_W),
  localparam int LOG_W = POS_W + 4
) (
  input  logic [MAG_W-1:0] mag,
  output logic [LOG_W-1:0] lg
);
  logic [POS_W-1:0] pos;
  logic [MAG_W-1:0] norm;

  always_comb begin
    pos = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (mag[i]) pos = POS_W'(i);
    end
    norm = mag << (POS_W'(MAG_W - 1) - pos);
    if (mag == '0) lg = '0;
    else           lg = {pos, norm[MAG_W-2 -: 4]};
  end
endmodule

// File: rtl/rtp_vec_ctl.sv
// Per-vector configuration capture and cell counter.
module rtp_vec_ctl #(
  parameter int MAG_W = 16,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sov,
  input  logic [MAG_W-1:0] cfg_thr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_en,
  output logic [MAG_W-1:0] eff_thr,
  output logic [1:0]       eff_mode,
  output logic             eff_en,
  output logic [IDX_W-1:0] cell_idx
);
  logic [MAG_W-1:0] thr_q;
  logic [1:0]       mode_q;
  logic             en_q;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce, cfg_ce;

  always_comb begin
    eff_thr  = sov ? cfg_thr  : thr_q;
    eff_mode = sov ? cfg_mode : mode_q;
    eff_en   = sov ? cfg_en   : en_q;
    cell_idx = sov ? '0 : cnt_q;
    cnt_d    = cell_idx + IDX_W'(1);
    cnt_ce   = fire;
    cfg_ce   = fire & sov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      thr_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (cfg_ce) begin
        thr_q  <= cfg_thr;
        mode_q <= cfg_mode;
        en_q   <= cfg_en;
      end
    end
  end
endmodule

// File: rtl/rtp_packer.sv
// Accumulates variable-width entries LSB-first and emits full or closing words.
module rtp_packer #(
  parameter int OUT_W  = 64,
  parameter int ENT_W  = 48,
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sov,
  input  logic              eov,
  input  logic              keep,
  input  logic [ENT_W-1:0]  entry,
  input  logic [FILL_W-1:0] ent_w,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last
);
  localparam int CMP_W = FILL_W + 2;

  logic [OUT_W-1:0]  acc_q, acc_d, merged, placed;
  logic [FILL_W-1:0] fill_q, fill_d, fill_base;
  logic [CMP_W-1:0]  fill_sum, next_end;
  logic              full, emit;

  always_comb begin
    fill_base = sov ? '0 : fill_q;
    placed    = OUT_W'(entry) << fill_base;
    merged    = (sov ? '0 : acc_q) | (keep ? placed : '0);
    fill_sum  = CMP_W'(fill_base) + (keep ? CMP_W'(ent_w) : '0);
    next_end  = fill_sum + CMP_W'(ent_w);
    full      = keep && (next_end > CMP_W'(OUT_W));
    emit      = fire && (full || eov);
    acc_d     = emit ? '0 : merged;
    fill_d    = emit ? '0 : FILL_W'(fill_sum);
    in_ready  = !out_valid || out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (fire) begin
        acc_q  <= acc_d;
        fill_q <= fill_d;
      end
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= merged;
        out_last  <= eov;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdr_thresh_pack.sv
module rdr_thresh_pack #(
  parameter int MAG_W = 16,
  parameter int PH_W  = 16,
  parameter int IDX_W = 16,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sov,
  input  logic             in_eov,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [PH_W-1:0]  in_phase,
  input  logic [MAG_W-1:0] cfg_thresh,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_thr_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);
  import rtp_pkg::*;

  localparam int LOG_W  = $clog2(MAG_W) + 4;
  localparam int PAY_W  = MAG_W + PH_W;
  localparam int ENT_W  = PAY_W + IDX_W;
  localparam int FILL_W = $clog2(OUT_W + 1);

  logic             in_fire, keep, eff_en;
  logic [MAG_W-1:0] eff_thr;
  logic [1:0]       eff_mode;
  logic [IDX_W-1:0] cell_idx;
  logic [LOG_W-1:0] log_val;
  logic [PAY_W-1:0] payload;
  logic [ENT_W-1:0] entry;
  logic [FILL_W-1:0] pay_w, ent_w;

  assign in_fire = in_valid & in_ready;

  rtp_vec_ctl #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(in_fire), .sov(in_sov),
    .cfg_thr(cfg_thresh), .cfg_mode(cfg_mode), .cfg_en(cfg_thr_en),
    .eff_thr(eff_thr), .eff_mode(eff_mode), .eff_en(eff_en),
    .cell_idx(cell_idx)
  );

  rtp_log8 #(.MAG_W(MAG_W)) u_log (.mag(in_mag), .lg(log_val));

  always_comb begin
    keep = !eff_en || (in_mag > eff_thr);
    case (fmt_e'(eff_mode))
      FMT_MAGPH: begin payload = {in_phase, in_mag};   pay_w = FILL_W'(PAY_W); end
      FMT_LOG:   begin payload = PAY_W'(log_val);      pay_w = FILL_W'(LOG_W); end
      default:   begin payload = PAY_W'(in_mag);       pay_w = FILL_W'(MAG_W); end
    endcase
    if (eff_en) begin
      entry = {payload, cell_idx};
      ent_w = pay_w + FILL_W'(IDX_W);
    end else begin
      entry = ENT_W'(payload);
      ent_w = pay_w;
    end
  end

  rtp_packer #(.OUT_W(OUT_W), .ENT_W(ENT_W), .FILL_W(FILL_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .fire(in_fire), .sov(in_sov), .eov(in_eov),
    .keep(keep), .entry(entry), .ent_w(ent_w), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );
endmodule

// File: rtl/rdr_thresh_pack_chk.sv
module rdr_thresh_pack_chk #(
  parameter int MAG_W = 16,
  parameter int PH_W  = 16,
  parameter int OUT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sov,
  input logic             in_eov,
  input logic [MAG_W-1:0] in_mag,
  input logic [PH_W-1:0]  in_phase,
  input logic [MAG_W-1:0] cfg_thresh,
  input logic [1:0]       cfg_mode,
  input logic             cfg_thr_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last
);
  // R10: no intake while a finished word waits
  a_r10_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: waiting word is held unchanged
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: an accepted end-of-vector sample closes the vector on the next cycle
  a_r8_last_follows_eov: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eov) |=> (out_valid && out_last));

  // R7: a new word only appears after an accepted sample
  a_r7_word_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind rdr_thresh_pack rdr_thresh_pack_chk u_chk (.*);

// File: tb/rdr_thresh_pack_bench.sv
module rdr_thresh_pack_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sov, in_eov;
  logic [15:0] in_mag, in_phase, cfg_thresh;
  logic [1:0]  cfg_mode;
  logic        cfg_thr_en;
  logic        out_valid, out_ready, out_last;
  logic [63:0] out_data;

  always #5 clk = ~clk;

  rdr_thresh_pack u_rdr_thresh_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sov(in_sov), .in_eov(in_eov), .in_mag(in_mag), .in_phase(in_phase),
    .cfg_thresh(cfg_thresh), .cfg_mode(cfg_mode), .cfg_thr_en(cfg_thr_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;

  // stimulus queues
  bit [15:0] st_mag[$], st_ph[$], st_thr[$];
  bit [1:0]  st_mode[$];
  bit        st_en[$], st_sov[$], st_eov[$];
  // expected words
  bit [63:0] ex_data[$];
  bit        ex_last[$];
  string     ex_tag[$];

  // reference model state
  bit [1:0]  m_mode;
  bit        m_en, m_first;
  bit [15:0] m_thr, m_idx;
  bit [63:0] m_acc;
  int        m_fill;
  string     m_tag;

  function automatic bit [7:0] ref_log(bit [15:0] m);
    int p;
    int mant;
    if (m == 0) return 8'd0;
    p = 15;
    while (!m[p]) p--;
    if (p >= 4) mant = int'(m >> (p - 4)) & 15;
    else        mant = int'(m << (4 - p)) & 15;
    return 8'(p * 16 + mant);
  endfunction

  task automatic check(bit ok, string tag, string what, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic begin_vec(bit [1:0] mode, bit en, bit [15:0] thr, string tag);
    m_mode = mode; m_en = en; m_thr = thr; m_tag = tag;
    m_idx = 0; m_acc = 0; m_fill = 0; m_first = 1'b1;
  endtask

  task automatic add_sample(bit [15:0] mag, bit [15:0] ph, bit eov);
    bit [63:0] pay, ent;
    int pw, w;
    bit kept;
    st_mag.push_back(mag); st_ph.push_back(ph);
    st_sov.push_back(m_first); st_eov.push_back(eov);
    if (m_first) begin
      st_thr.push_back(m_thr); st_mode.push_back(m_mode); st_en.push_back(m_en);
    end else begin
      // R9: configuration pins scrambled on non-start samples
      st_thr.push_back(16'($urandom)); st_mode.push_back(2'($urandom));
      st_en.push_back(1'($urandom));
    end
    m_first = 1'b0;
    case (m_mode)
      2'd1:    begin pay = {32'd0, ph, mag};           pw = 32; end
      2'd2:    begin pay = {56'd0, ref_log(mag)};      pw = 8;  end
      default: begin pay = {48'd0, mag};               pw = 16; end
    endcase
    kept = !m_en || (mag > m_thr);
    w = pw + (m_en ? 16 : 0);
    ent = m_en ? ((pay << 16) | {48'd0, m_idx}) : pay;
    if (kept) begin
      m_acc = m_acc | (ent << m_fill);
      m_fill += w;
    end
    if ((kept && (m_fill + w > 64)) || eov) begin
      ex_data.push_back(m_acc); ex_last.push_back(eov); ex_tag.push_back(m_tag);
      m_acc = 0; m_fill = 0;
    end
    m_idx++;
  endtask

  task automatic add_list(bit [15:0] mags[], bit [15:0] phs[]);
    foreach (mags[i]) add_sample(mags[i], phs[i], i == mags.size() - 1);
  endtask

  initial begin
    int ptr, cyc, len;
    bit hold, drain, stalled;
    bit [63:0] stall_data;
    bit stall_last;
    bit [15:0] ph6[];
    void'($urandom(32'd20240611));

    // R2: boundary at threshold 100
    begin_vec(2'd0, 1'b1, 16'd100, "R2");
    add_list('{16'd100, 16'd101, 16'd99, 16'hFFFF}, '{16'd1, 16'd2, 16'd3, 16'd4});
    // R3: discarded samples still advance the index
    begin_vec(2'd0, 1'b1, 16'd0, "R3");
    add_list('{16'd0, 16'd5, 16'd0, 16'd7, 16'd0, 16'd9}, '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0});
    // R4: threshold disabled, magnitude+phase, no index
    begin_vec(2'd1, 1'b0, 16'hFFFF, "R4");
    for (int i = 0; i < 5; i++) add_sample(16'($urandom), 16'($urandom), i == 4);
    // R5: reserved mode acts as magnitude
    begin_vec(2'd3, 1'b0, 16'd0, "R5");
    for (int i = 0; i < 6; i++) add_sample(16'($urandom), 16'($urandom), i == 5);
    begin_vec(2'd1, 1'b1, 16'd10, "R5");
    add_list('{16'd11, 16'd10, 16'd300}, '{16'hAAAA, 16'hBBBB, 16'hCCCC});
    // R6: log magnitude corners
    begin_vec(2'd2, 1'b0, 16'd0, "R6");
    ph6 = new[10];
    foreach (ph6[i]) ph6[i] = 16'($urandom);
    add_list('{16'd0, 16'd1, 16'd2, 16'd3, 16'd15, 16'd16, 16'd31, 16'h8000, 16'hFFFF, 16'h1234}, ph6);
    // R7: 24-bit entries, two per word
    begin_vec(2'd2, 1'b1, 16'd0, "R7");
    for (int i = 0; i < 7; i++) add_sample(16'($urandom) | 16'd1, 16'd0, i == 6);
    // R8: everything discarded, and a single-sample vector
    begin_vec(2'd0, 1'b1, 16'hFFFF, "R8");
    for (int i = 0; i < 3; i++) add_sample(16'($urandom), 16'd0, i == 2);
    begin_vec(2'd1, 1'b1, 16'd0, "R8");
    add_sample(16'd77, 16'd88, 1'b1);
    // R9: mid-vector configuration noise
    begin_vec(2'd1, 1'b1, 16'd50, "R9");
    for (int i = 0; i < 8; i++) add_sample(16'($urandom % 100), 16'($urandom), i == 7);
    // random vectors
    for (int v = 0; v < 150; v++) begin
      begin_vec(2'($urandom), 1'($urandom), 16'($urandom % 3 == 0 ? 0 : $urandom), "R7");
      len = 1 + int'($urandom % 20);
      for (int i = 0; i < len; i++)
        add_sample(($urandom % 4 == 0) ? 16'($urandom % 8) : 16'($urandom), 16'($urandom), i == len - 1);
    end

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_sov = 0; in_eov = 0; in_mag = 0; in_phase = 0;
    cfg_thresh = 0; cfg_mode = 0; cfg_thr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    ptr = 0; cyc = 0; hold = 0; drain = 0; stalled = 0;
    stall_data = 0; stall_last = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "R7", "watchdog expired", 64'(cyc), 64'd0);
        break;
      end
      drain = (ptr == st_mag.size());
      out_ready = drain ? 1'b1 : ($urandom % 4 != 0);
      if (ptr < st_mag.size() && (hold || ($urandom % 5 != 0))) begin
        in_valid = 1'b1;
        in_sov = st_sov[ptr]; in_eov = st_eov[ptr];
        in_mag = st_mag[ptr]; in_phase = st_ph[ptr];
        cfg_thresh = st_thr[ptr]; cfg_mode = st_mode[ptr]; cfg_thr_en = st_en[ptr];
      end else begin
        in_valid = 1'b0;
        in_sov = 1'($urandom); in_eov = 1'($urandom);
      end
      #1;
      if (stalled) begin
        check(out_valid && out_data == stall_data && out_last == stall_last,
              "R10", "held word", out_data, stall_data);
      end
      stalled = 0;
      if (out_valid && !out_ready) begin
        check(in_ready == 1'b0, "R10", "in_ready during stall", 64'(in_ready), 64'd0);
        stalled = 1; stall_data = out_data; stall_last = out_last;
      end
      if (out_valid && out_ready) begin
        if (ex_data.size() == 0) begin
          check(1'b0, "R7", "unexpected word", out_data, 64'd0);
        end else begin
          string tg;
          bit [63:0] ed;
          bit el;
          tg = ex_tag.pop_front(); ed = ex_data.pop_front(); el = ex_last.pop_front();
          check(out_data == ed, tg, "word data", out_data, ed);
          check(out_last == el, "R8", "word last flag", 64'(out_last), 64'(el));
        end
      end
      if (in_valid && in_ready) begin
        ptr++;
        hold = 1'b0;
      end else begin
        hold = in_valid;
      end
      if (ptr == st_mag.size() && ex_data.size() == 0 && !out_valid) break;
    end
    check(ex_data.size() == 0, "R8", "words outstanding at end", 64'(ex_data.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule